// File: doc/BRIEF.md
# Conditional-Access Section Filter Pair

Two section filters watch one byte stream of transport packet payloads. Each byte arrives with its packet PID, a flag that marks the first byte of a section, and a flag that marks the byte as part of a packet with an uncorrectable error. A filter checks the PID, a bit-masked table_id and a configurable number of bit-masked payload bytes that follow the three-byte section header. It copies a matching section into its own 256-byte buffer, raises a status bit with a one-cycle interrupt pulse, and reports how many 16-bit words it has written.

A filter accepts a new section only while its buffer is empty. A section that is too long is cut off at the buffer size and a too-long flag is set. A packet error during acquisition discards the partial section. With equal-conditions enabled, the even filter takes the first matching section and the odd filter takes one only when the even buffer is still full. Software empties a buffer by reading its last valid word or by pulsing that filter's release bit. Both actions re-arm the filter.

Each filter runs one state machine. `S_IDLE` moves to `S_HEAD` on an accepted first byte. `S_HEAD` moves to `S_BODY` after the third header byte, or straight to `S_FULL` when the length field is zero. `S_HEAD` and `S_BODY` go back to `S_IDLE` on a packet error. `S_BODY` also goes back to `S_IDLE` on a compare mismatch. `S_BODY` moves to `S_FULL` on the last section byte or when the buffer fills. `S_FULL` returns to `S_IDLE` on release or on a read of the last valid word.

Top module: `ca_filter_pair`

## Requirements
- R1: After reset, stat, irq and too_long are 0 and both word counts are 0.
- R2: A filter considers only bytes with in_valid high and in_pid equal to its configured PID. Bytes of other PIDs never start, advance or abort a capture. With PID_MASKABLE set, PID bits whose mask bit is 0 are not compared.
- R3: A capture starts only on a byte with in_sec_start high whose value equals cfg_tid on every bit where cfg_tid_mask is 1. Bits where the mask is 0 are ignored.
- R4: Section bytes 3 to 3+CMP_BYTES-1 (byte 0 is table_id, bytes 1 and 2 hold a 12-bit length in the low nibble of byte 1 and all of byte 2) are compared with cfg_cmp under cfg_cmp_mask, compare byte k at bits [8k+7:8k]. Any mismatch discards the section.
- R5: When all length+3 bytes are stored, stat goes high in the cycle after the last byte, irq pulses high for exactly that one cycle, and word_cnt shows ceil((length+3)/2).
- R6: A section longer than 256 bytes stops at 256 stored bytes. It then raises stat, irq and too_long, with word_cnt 128. too_long clears when the filter is re-armed.
- R7: A filter starts a capture only while its cfg_en bit is 1 and its stat is 0. A full buffer keeps its contents and count.
- R8: With cfg_eq_cond set, filter 1 starts a capture only if filter 0's stat was 1 at the first byte. Filter 0 is never gated.
- R9: in_pkt_err on a byte of the filter's PID during acquisition aborts the capture. The section is lost and the next section can be captured.
- R10: A read with rd_en, rd_sel and rd_addr a returns, on rd_data in the next cycle, section byte 2a in bits [15:8] and byte 2a+1 in bits [7:0]. Reading word word_cnt-1 of a full filter clears its stat and re-arms it.
- R11: A one-cycle rel pulse on a full filter clears its stat, zeroes its word count and re-arms it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | A payload byte is present |
| in_data | input | 8 | Payload byte |
| in_pid | input | 13 | PID of the packet carrying the byte |
| in_sec_start | input | 1 | Byte is the first byte (table_id) of a section |
| in_pkt_err | input | 1 | Byte belongs to an errored packet |
| cfg_en | input | 2 | Per-filter enable |
| cfg_eq_cond | input | 1 | Equal-conditions alternation |
| cfg_pid | input | 26 | PID per filter, 13 bits each |
| cfg_pid_mask | input | 26 | PID compare masks, used when PID_MASKABLE is 1 |
| cfg_tid | input | 16 | table_id per filter |
| cfg_tid_mask | input | 16 | table_id compare masks |
| cfg_cmp | input | 2*CMP_BYTES*8 | Payload compare values per filter |
| cfg_cmp_mask | input | 2*CMP_BYTES*8 | Payload compare masks per filter |
| rel | input | 2 | Per-filter buffer release pulse |
| rd_en | input | 1 | Buffer read request |
| rd_sel | input | 1 | Filter to read |
| rd_addr | input | 7 | Word address in the buffer |
| rd_data | output | 16 | Read word, one cycle after the request |
| stat | output | 2 | Buffer holds a complete section |
| irq | output | 2 | One-cycle pulse when a buffer is loaded |
| too_long | output | 2 | Loaded section was truncated |
| word_cnt | output | 16 | Valid words per filter, 8 bits each |

## Verification
The assertions assume a few things about the inputs. in_pid, in_sec_start and in_pkt_err describe the byte that is present in the same cycle. in_sec_start appears only on the table_id byte of a section. The configuration does not change while a filter is in `S_HEAD` or `S_BODY`. The stimulus keeps to these rules: it changes configuration only between sections, sends each section as an unbroken run of its PID's bytes with idle gaps but no interleaved starts, and issues release and read only after the stream has gone quiet. A behavioural model driven by the same inputs predicts status, interrupt, truncation flag, word counts and read data in every cycle.

// File: rtl/ca_sec_pkg.sv
package ca_sec_pkg;
    localparam int PID_W = 13;

    typedef enum logic [1:0] {
        S_IDLE,
        S_HEAD,
        S_BODY,
        S_FULL
    } sec_state_e;
endpackage

// File: rtl/ca_sec_buf.sv
module ca_sec_buf #(
    parameter  int DEPTH_B = 256,
    localparam int AW      = $clog2(DEPTH_B),
    localparam int RW      = AW - 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic          re,
    input  logic [RW-1:0] raddr,
    output logic [15:0]   rdata
);
    logic [7:0] mem [DEPTH_B];

    // even byte of a word sits in the upper half
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= {mem[{raddr, 1'b0}], mem[{raddr, 1'b1}]};
    end
endmodule

// File: rtl/ca_sec_filter.sv
module ca_sec_filter
    import ca_sec_pkg::*;
#(
    parameter  int CMP_BYTES    = 7,
    parameter  bit PID_MASKABLE = 1'b0,
    parameter  int BUF_BYTES    = 256,
    localparam int AW  = $clog2(BUF_BYTES),
    localparam int CW  = AW + 1,
    localparam int RW  = AW - 1,
    localparam int WCW = RW + 1,
    localparam int CB  = CMP_BYTES * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic [PID_W-1:0] in_pid,
    input  logic             in_sec_start,
    input  logic             in_pkt_err,
    input  logic             en,
    input  logic             eligible,
    input  logic [PID_W-1:0] pid,
    input  logic [PID_W-1:0] pid_mask,
    input  logic [7:0]       tid,
    input  logic [7:0]       tid_mask,
    input  logic [CB-1:0]    cmp_val,
    input  logic [CB-1:0]    cmp_mask,
    input  logic             rel,
    input  logic             rd_en,
    input  logic [RW-1:0]    rd_addr,
    output logic [15:0]      rd_data,
    output logic             stat,
    output logic             irq,
    output logic             too_long,
    output logic [WCW-1:0]   word_cnt
);
    sec_state_e       st_q, st_d;
    logic [CW-1:0]    cnt_q;
    logic [12:0]      tot_q;
    logic [3:0]       lhi_q;
    logic             tl_q, irq_q;
    logic             wr, fire, trunc;
    logic             pid_hit, tid_ok, cmp_bad, last_rd;
    logic [PID_W-1:0] pmask;
    logic [12:0]      tot_new;
    logic [WCW-1:0]   words;

    assign pmask   = pid_mask | {PID_W{!PID_MASKABLE}};
    assign pid_hit = in_valid && (((in_pid ^ pid) & pmask) == '0);
    assign tid_ok  = ((in_data ^ tid) & tid_mask) == 8'h00;
    assign tot_new = {1'b0, lhi_q, in_data} + 13'd3;
    assign words   = WCW'((cnt_q + CW'(1)) >> 1);
    assign last_rd = ({1'b0, rd_addr} == (words - WCW'(1)));

    always_comb begin
        cmp_bad = 1'b0;
        for (int i = 0; i < CMP_BYTES; i++) begin
            if (cnt_q == CW'(i + 3))
                cmp_bad = ((in_data ^ cmp_val[i*8 +: 8]) & cmp_mask[i*8 +: 8]) != 8'h00;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // next state and per-cycle controls
    always_comb begin
        st_d  = st_q;
        wr    = 1'b0;
        fire  = 1'b0;
        trunc = 1'b0;
        unique case (st_q)
            S_IDLE: begin
                if (pid_hit && in_sec_start && en && eligible && tid_ok) begin
                    wr   = 1'b1;
                    st_d = S_HEAD;
                end
            end
            S_HEAD: begin
                if (pid_hit) begin
                    if (in_pkt_err) begin
                        st_d = S_IDLE;
                    end else begin
                        wr = 1'b1;
                        if (cnt_q == CW'(2)) begin
                            if (tot_new == 13'd3) begin
                                st_d = S_FULL;
                                fire = 1'b1;
                            end else begin
                                st_d = S_BODY;
                            end
                        end
                    end
                end
            end
            S_BODY: begin
                if (pid_hit) begin
                    if (in_pkt_err || cmp_bad) begin
                        st_d = S_IDLE;
                    end else begin
                        wr = 1'b1;
                        if (13'(cnt_q) + 13'd1 == tot_q) begin
                            st_d = S_FULL;
                            fire = 1'b1;
                        end else if (cnt_q == CW'(BUF_BYTES - 1)) begin
                            st_d  = S_FULL;
                            fire  = 1'b1;
                            trunc = 1'b1;
                        end
                    end
                end
            end
            S_FULL: begin
                if (rel || (rd_en && last_rd)) st_d = S_IDLE;
            end
            default: st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tot_q <= '0;
            lhi_q <= '0;
            tl_q  <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= fire;
            if (wr)                  cnt_q <= cnt_q + CW'(1);
            else if (st_d == S_IDLE) cnt_q <= '0;
            if (wr && st_q == S_HEAD && cnt_q == CW'(1)) lhi_q <= in_data[3:0];
            if (wr && st_q == S_HEAD && cnt_q == CW'(2)) tot_q <= tot_new;
            if (trunc)               tl_q <= 1'b1;
            else if (st_d == S_IDLE) tl_q <= 1'b0;
        end
    end

    ca_sec_buf #(.DEPTH_B(BUF_BYTES)) u_buf (
        .clk   (clk),
        .we    (wr),
        .waddr (cnt_q[AW-1:0]),
        .wdata (in_data),
        .re    (rd_en),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    assign stat     = (st_q == S_FULL);
    assign irq      = irq_q;
    assign too_long = tl_q;
    assign word_cnt = stat ? words : '0;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(BUF_BYTES)); // R6
    AST_IRQ_WITH_STAT: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> stat); // R5
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R5
    AST_TRUNC_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        too_long |-> (stat && word_cnt == WCW'(BUF_BYTES / 2))); // R6
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat && !rel && !rd_en) |=> stat); // R11
endmodule

// File: rtl/ca_filter_pair.sv
module ca_filter_pair
    import ca_sec_pkg::*;
#(
    parameter  int CMP_BYTES    = 7,
    parameter  bit PID_MASKABLE = 1'b0,
    parameter  int BUF_BYTES    = 256,
    localparam int NF  = 2,
    localparam int RW  = $clog2(BUF_BYTES) - 1,
    localparam int WCW = RW + 1,
    localparam int CB  = CMP_BYTES * 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [7:0]          in_data,
    input  logic [PID_W-1:0]    in_pid,
    input  logic                in_sec_start,
    input  logic                in_pkt_err,
    input  logic [NF-1:0]       cfg_en,
    input  logic                cfg_eq_cond,
    input  logic [NF*PID_W-1:0] cfg_pid,
    input  logic [NF*PID_W-1:0] cfg_pid_mask,
    input  logic [NF*8-1:0]     cfg_tid,
    input  logic [NF*8-1:0]     cfg_tid_mask,
    input  logic [NF*CB-1:0]    cfg_cmp,
    input  logic [NF*CB-1:0]    cfg_cmp_mask,
    input  logic [NF-1:0]       rel,
    input  logic                rd_en,
    input  logic                rd_sel,
    input  logic [RW-1:0]       rd_addr,
    output logic [15:0]         rd_data,
    output logic [NF-1:0]       stat,
    output logic [NF-1:0]       irq,
    output logic [NF-1:0]       too_long,
    output logic [NF*WCW-1:0]   word_cnt
);
    logic [15:0] rdat [NF];
    logic        elig [NF];
    logic        sel_q;

    for (genvar g = 0; g < NF; g++) begin : g_flt
        if (g == 0) begin : g_even
            assign elig[g] = 1'b1;
        end else begin : g_odd
            // odd filter only takes a section while the even buffer is occupied
            assign elig[g] = !cfg_eq_cond || stat[0];
        end

        ca_sec_filter #(
            .CMP_BYTES    (CMP_BYTES),
            .PID_MASKABLE (PID_MASKABLE),
            .BUF_BYTES    (BUF_BYTES)
        ) u_flt (
            .clk          (clk),
            .rst_n        (rst_n),
            .in_valid     (in_valid),
            .in_data      (in_data),
            .in_pid       (in_pid),
            .in_sec_start (in_sec_start),
            .in_pkt_err   (in_pkt_err),
            .en           (cfg_en[g]),
            .eligible     (elig[g]),
            .pid          (cfg_pid[g*PID_W +: PID_W]),
            .pid_mask     (cfg_pid_mask[g*PID_W +: PID_W]),
            .tid          (cfg_tid[g*8 +: 8]),
            .tid_mask     (cfg_tid_mask[g*8 +: 8]),
            .cmp_val      (cfg_cmp[g*CB +: CB]),
            .cmp_mask     (cfg_cmp_mask[g*CB +: CB]),
            .rel          (rel[g]),
            .rd_en        (rd_en && (rd_sel == 1'(g))),
            .rd_addr      (rd_addr),
            .rd_data      (rdat[g]),
            .stat         (stat[g]),
            .irq          (irq[g]),
            .too_long     (too_long[g]),
            .word_cnt     (word_cnt[g*WCW +: WCW])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sel_q <= 1'b0;
        else if (rd_en) sel_q <= rd_sel;
    end

    assign rd_data = sel_q ? rdat[1] : rdat[0];
endmodule

// File: tb/tb_ca_filter_pair.sv
module tb_ca_filter_pair;
    localparam int N = 7;
    localparam int HALF = 4; // 8 ns period

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 0, in_sec_start = 0, in_pkt_err = 0;
    logic [7:0] in_data = 0;
    logic [12:0] in_pid = 0;
    logic [1:0] cfg_en = 2'b11, rel = 0;
    logic cfg_eq_cond = 0, rd_en = 0, rd_sel = 0;
    logic [25:0] cfg_pid, cfg_pid_mask;
    logic [15:0] cfg_tid, cfg_tid_mask;
    logic [2*N*8-1:0] cfg_cmp, cfg_cmp_mask;
    logic [6:0] rd_addr = 0;
    logic [15:0] rd_data, word_cnt;
    logic [1:0] stat, irq, too_long;

    always #HALF clk = ~clk;

    ca_filter_pair dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_pid(in_pid),
        .in_sec_start(in_sec_start), .in_pkt_err(in_pkt_err), .cfg_en(cfg_en),
        .cfg_eq_cond(cfg_eq_cond), .cfg_pid(cfg_pid), .cfg_pid_mask(cfg_pid_mask),
        .cfg_tid(cfg_tid), .cfg_tid_mask(cfg_tid_mask), .cfg_cmp(cfg_cmp),
        .cfg_cmp_mask(cfg_cmp_mask), .rel(rel), .rd_en(rd_en), .rd_sel(rd_sel),
        .rd_addr(rd_addr), .rd_data(rd_data), .stat(stat), .irq(irq),
        .too_long(too_long), .word_cnt(word_cnt)
    );

    int nchk = 0, nerr = 0;
    string cur_req = "R1";
    bit mon_on = 0, done = 0;
    int cmpv [N], cmpm [N];

    task automatic chk(bit ok, string req, string what, int act, int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // behavioural model: 0 empty, 1 acquiring, 2 holding
    int mst [2], ncap [2], tot [2];
    int cbuf [2][256];
    bit tl [2];
    bit [1:0] exp_irq;
    bit exp_rd_v, lo_chk;
    int exp_hi, exp_lo;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int f = 0; f < 2; f++) begin mst[f] = 0; ncap[f] = 0; tl[f] = 0; tot[f] = 0; end
            exp_irq = 0; exp_rd_v = 0;
        end else begin
            int old0;
            old0 = mst[0]; exp_irq = 0; exp_rd_v = 0;
            for (int f = 0; f < 2; f++) begin
                bit hit, elig, leave;
                int n, a;
                hit = in_valid && in_pid == cfg_pid[f*13 +: 13];
                elig = (f == 0) || !cfg_eq_cond || old0 == 2;
                leave = 0;
                case (mst[f])
                    0: if (hit && in_sec_start && cfg_en[f] && elig &&
                           ((in_data ^ cfg_tid[f*8 +: 8]) & cfg_tid_mask[f*8 +: 8]) == 0) begin
                        cbuf[f][0] = in_data; ncap[f] = 1; mst[f] = 1;
                    end
                    1: if (hit) begin
                        n = ncap[f];
                        if (in_pkt_err) mst[f] = 0;
                        else if (n >= 3 && n < 3 + N && ((in_data ^ cmpv[n-3]) & cmpm[n-3]) != 0) mst[f] = 0;
                        else begin
                            cbuf[f][n] = in_data; ncap[f] = n + 1;
                            if (n == 2) tot[f] = (cbuf[f][1] % 16) * 256 + in_data + 3;
                            if (n >= 2 && ncap[f] == tot[f]) begin mst[f] = 2; exp_irq[f] = 1; end
                            else if (ncap[f] == 256) begin mst[f] = 2; exp_irq[f] = 1; tl[f] = 1; end
                        end
                    end
                    2: begin
                        if (rd_en && rd_sel == f) begin
                            a = rd_addr;
                            exp_rd_v = 1; exp_hi = cbuf[f][2*a];
                            lo_chk = (2*a + 1) < ncap[f];
                            exp_lo = lo_chk ? cbuf[f][2*a+1] : 0;
                            if (a == (ncap[f] + 1) / 2 - 1) leave = 1;
                        end
                        if (rel[f]) leave = 1;
                        if (leave) begin mst[f] = 0; tl[f] = 0; ncap[f] = 0; end
                    end
                    default: mst[f] = 0;
                endcase
                if (mst[f] == 0) ncap[f] = 0;
            end
        end
    end

    // compared every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            for (int f = 0; f < 2; f++) begin
                chk(stat[f] == (mst[f] == 2), cur_req, "stat", stat[f], mst[f] == 2);
                chk(irq[f] == exp_irq[f], cur_req, "irq", irq[f], exp_irq[f]);
                chk(too_long[f] == tl[f], cur_req, "too_long", too_long[f], tl[f]);
                chk(word_cnt[f*8 +: 8] == ((mst[f] == 2) ? (ncap[f] + 1) / 2 : 0), cur_req, "word_cnt",
                    word_cnt[f*8 +: 8], (mst[f] == 2) ? (ncap[f] + 1) / 2 : 0);
            end
            if (exp_rd_v) begin
                chk(rd_data[15:8] == exp_hi, "R10", "rd_hi", rd_data[15:8], exp_hi);
                if (lo_chk) chk(rd_data[7:0] == exp_lo, "R10", "rd_lo", rd_data[7:0], exp_lo);
            end
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            in_valid = 0; in_sec_start = 0; in_pkt_err = 0; rel = 0; rd_en = 0;
        end
    endtask

    task automatic send_sec(int pid, int tid, int len, int bad_at, int err_at);
        int total;
        total = len + 3;
        for (int i = 0; i < total; i++) begin
            logic [7:0] b;
            if (i % 5 == 4) idle(1);
            if (i == 0) b = 8'(tid);
            else if (i == 1) b = {4'hB, 4'(len >> 8)};
            else if (i == 2) b = 8'(len);
            else if (i < 3 + N) b = (i == 9) ? 8'h5A : 8'(cmpv[i-3]);
            else b = 8'(i * 7 + len);
            if (i == bad_at) b = b ^ 8'h01;
            @(posedge clk); #1;
            in_valid = 1; in_data = b; in_pid = 13'(pid);
            in_sec_start = (i == 0); in_pkt_err = (i == err_at);
        end
        idle(2);
    endtask

    task automatic release_f(int f);
        @(posedge clk); #1; rel = 2'b01 << f;
        idle(2);
    endtask

    task automatic read_all(int f);
        int w;
        w = (ncap[f] + 1) / 2;
        for (int a = 0; a < w; a++) begin
            @(posedge clk); #1; rd_en = 1; rd_sel = 1'(f); rd_addr = 7'(a);
        end
        idle(2);
    endtask

    task automatic expect_now(bit [1:0] s, int w0, int w1, string req);
        @(negedge clk);
        chk(stat == s, req, "stat_vec", stat, s);
        if (s[0]) chk(word_cnt[7:0] == w0, req, "words0", word_cnt[7:0], w0);
        if (s[1]) chk(word_cnt[15:8] == w1, req, "words1", word_cnt[15:8], w1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < N; k++) begin
            cmpv[k] = 8'h10 + k;
            cmpm[k] = (k == 6) ? 0 : 8'hFF;
        end
        for (int f = 0; f < 2; f++) begin
            cfg_pid[f*13 +: 13] = 13'h100;
            cfg_pid_mask[f*13 +: 13] = 13'h1FFF;
            cfg_tid[f*8 +: 8] = 8'h80;
            cfg_tid_mask[f*8 +: 8] = 8'hFE;
            for (int k = 0; k < N; k++) begin
                cfg_cmp[(f*N + k)*8 +: 8] = 8'(cmpv[k]);
                cfg_cmp_mask[(f*N + k)*8 +: 8] = 8'(cmpm[k]);
            end
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        @(negedge clk);
        chk(stat == 0, "R1", "stat", stat, 0);
        chk(irq == 0, "R1", "irq", irq, 0);
        chk(too_long == 0, "R1", "too_long", too_long, 0);
        chk(word_cnt == 0, "R1", "word_cnt", word_cnt, 0);
        mon_on = 1;

        cur_req = "R5";
        send_sec(13'h100, 8'h80, 21, -1, -1);
        expect_now(2'b11, 12, 12, "R5");
        cur_req = "R10";
        read_all(0);
        expect_now(2'b10, 0, 12, "R10");
        cur_req = "R11";
        release_f(1);
        expect_now(2'b00, 0, 0, "R11");

        cur_req = "R2";
        send_sec(13'h101, 8'h80, 21, -1, -1);
        expect_now(2'b00, 0, 0, "R2");

        cur_req = "R3";
        send_sec(13'h100, 8'h90, 21, -1, -1);
        expect_now(2'b00, 0, 0, "R3");
        send_sec(13'h100, 8'h81, 10, -1, -1);
        expect_now(2'b11, 7, 7, "R3");
        release_f(0); release_f(1);

        cur_req = "R4";
        send_sec(13'h100, 8'h80, 21, 5, -1);
        expect_now(2'b00, 0, 0, "R4");

        cur_req = "R6";
        send_sec(13'h100, 8'h80, 300, -1, -1);
        expect_now(2'b11, 128, 128, "R6");
        @(negedge clk); chk(too_long == 2'b11, "R6", "too_long", too_long, 3);
        release_f(0); release_f(1);
        @(negedge clk); chk(too_long == 2'b00, "R6", "too_long_clr", too_long, 0);

        cur_req = "R7";
        cfg_en = 2'b01;
        send_sec(13'h100, 8'h80, 21, -1, -1);
        expect_now(2'b01, 12, 0, "R7");
        send_sec(13'h100, 8'h80, 25, -1, -1);
        expect_now(2'b01, 12, 0, "R7");
        release_f(0);
        cfg_en = 2'b11;

        cur_req = "R8";
        cfg_eq_cond = 1;
        send_sec(13'h100, 8'h80, 21, -1, -1);
        expect_now(2'b01, 12, 0, "R8");
        send_sec(13'h100, 8'h80, 25, -1, -1);
        expect_now(2'b11, 12, 14, "R8");
        send_sec(13'h100, 8'h80, 31, -1, -1);
        expect_now(2'b11, 12, 14, "R8");
        release_f(0); release_f(1);
        cfg_eq_cond = 0;

        cur_req = "R9";
        send_sec(13'h100, 8'h80, 21, -1, 12);
        expect_now(2'b00, 0, 0, "R9");
        send_sec(13'h100, 8'h80, 21, -1, -1);
        expect_now(2'b11, 12, 12, "R9");
        release_f(0); release_f(1);
        expect_now(2'b00, 0, 0, "R11");

        idle(3);
        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule